// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block sits beside the command engine of a 1 MB serial flash. It keeps the protection fields of the status register: a three-bit protection level and a lock-down bit. For every program or erase request it decides whether the operation may touch the array. The array is addressed by 20 bits. It is divided into sixteen 64 KB blocks, and each block is divided into sixteen 4 KB sectors. The protection level selects a region made of whole blocks. That region is a power-of-two fraction of the array.

An elaboration-time parameter anchors the protected region at the high end of the address space or at address zero. A status-register write changes the fields unless the write-protect pin is low while lock-down is set; in that case the write is dropped. Each operation request is answered one clock later with a valid strobe and an allow flag. A denied request also produces a one-cycle error pulse.

Top module: `flash_wp_ctrl`

## Requirements
- R1: On synchronous reset the protection level becomes 3'b111 and lock-down becomes 0, so the read-back is 8'h1C and no decision strobe is raised.
- R2: The read-back byte carries lock-down at bit 7 and the level at bits 4:2. Bits 6:5 and 1:0 always read 0.
- R3: A status write updates both the level and lock-down when the write-protect pin is high, or when lock-down is currently 0. The new value appears in the read-back one clock later.
- R4: When the write-protect pin is low and lock-down is 1, a status write changes neither field.
- R5: With top anchoring, the region grows down from the top of the array. Level 0 protects nothing. Levels 1, 2, 3 and 4 protect the highest 1, 2, 4 and 8 blocks. Levels 5 to 7 protect all 16 blocks.
- R6: With bottom anchoring, the same level codes protect the lowest 1, 2, 4 or 8 blocks, counted from address zero. Level 0 protects nothing, and levels 5 to 7 protect everything.
- R7: Operation codes are 0 for page program, 1 for sector erase and 2 for block erase. Each is denied when the 64 KB block that holds its address (bits 19:16) lies in the protected region, and allowed otherwise, whatever the sector and byte offsets are.
- R8: Operation code 3 (chip erase) is allowed only when the level is 3'b000, whatever its address.
- R9: A request sampled at a clock edge gives a one-cycle valid strobe at that edge, together with allow and, on denial only, a one-cycle error pulse. The decision uses the fields held before any status write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sr_wr_en | input | 1 | Status-register write strobe |
| sr_wr_level | input | 3 | New protection level |
| sr_wr_lock | input | 1 | New lock-down value |
| wp_pin | input | 1 | Write-protect pin level (low engages lock-down) |
| op_req | input | 1 | Operation request strobe |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | input | 20 | Target byte address |
| op_valid | output | 1 | Decision strobe, one clock after the request |
| op_allow | output | 1 | Operation may proceed (qualified by op_valid) |
| op_err | output | 1 | One-cycle pulse on a denied operation |
| sr_rdback | output | 8 | Status read-back byte |

## Verification
The bench runs two copies of the block, one anchored at the top and one at the bottom. For every level code, every block, several sectors and offsets, and all four operation kinds, it compares the decision with an expected value worked out from block counts. A boundary that is off by one block would wrongly allow or deny the block next to the edge of the region. A level decode that does not saturate would leave codes 5 to 7 protecting too little. The bench also checks chip erase with a nonzero level and an address in an unprotected block; a chip erase that used the address test would be allowed there when it should be denied. The lock sequence alternates the pin level with lock-down set and clear. A design that ignored the pin would freeze fields it should accept. A design that ignored lock-down, or updated only one of the two fields, would let a write through that should be dropped.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [1:0] {
    OP_PAGE_PROG   = 2'd0,
    OP_SECT_ERASE  = 2'd1,
    OP_BLOCK_ERASE = 2'd2,
    OP_CHIP_ERASE  = 2'd3
  } op_kind_e;

  localparam int RB_LOCK_POS = 7;
  localparam int RB_LVL_LSB  = 2;

endpackage

// File: rtl/wp_field_reg.sv
module wp_field_reg #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_level,
  input  logic             wr_lock,
  input  logic             wp_pin,
  output logic [LVL_W-1:0] level,
  output logic             lock
);

  logic wr_ok;

  // pin low together with lock-down set freezes both fields
  assign wr_ok = wr_en && (wp_pin || !lock);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '1;
      lock  <= 1'b0;
    end else if (wr_ok) begin
      level <= wr_level;
      lock  <= wr_lock;
    end
  end

endmodule

// File: rtl/wp_region_match.sv
module wp_region_match #(
  parameter int BLK_W      = 4,
  parameter int LVL_W      = 3,
  parameter bit TOP_ANCHOR = 1'b1
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [LVL_W-1:0] level,
  output logic             hit
);

  localparam logic [LVL_W:0] MAX_LVL = (LVL_W+1)'(BLK_W);
  localparam logic [BLK_W:0] ALL_BLK = (BLK_W+1)'(1) << BLK_W;

  logic [BLK_W:0] span;

  // number of protected blocks: 0, then 1,2,4,..., then saturate at all
  always_comb begin
    if (level == '0)
      span = '0;
    else if ({1'b0, level} > MAX_LVL)
      span = ALL_BLK;
    else
      span = (BLK_W+1)'(1) << (level - 1'b1);
  end

  generate
    if (TOP_ANCHOR) begin : g_top
      logic [BLK_W:0] reach;
      // blk + span overflows the block count exactly when blk is in the top span
      assign reach = {1'b0, blk} + span;
      assign hit   = reach[BLK_W];
    end else begin : g_bottom
      assign hit = ({1'b0, blk} < span);
    end
  endgenerate

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int BLK_W      = 4,
  parameter int LVL_W      = 3,
  parameter int RB_W       = 8,
  parameter bit TOP_ANCHOR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sr_wr_en,
  input  logic [LVL_W-1:0]  sr_wr_level,
  input  logic              sr_wr_lock,
  input  logic              wp_pin,
  input  logic              op_req,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              op_valid,
  output logic              op_allow,
  output logic              op_err,
  output logic [RB_W-1:0]   sr_rdback
);

  import flash_wp_pkg::*;

  localparam int BLK_LSB = ADDR_W - BLK_W;

  logic [LVL_W-1:0] level;
  logic             lock;
  logic             region_hit;
  logic             allow_d;
  op_kind_e         kind;

  wp_field_reg #(.LVL_W(LVL_W)) u_fields (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (sr_wr_en),
    .wr_level (sr_wr_level),
    .wr_lock  (sr_wr_lock),
    .wp_pin   (wp_pin),
    .level    (level),
    .lock     (lock)
  );

  // erase targets are block-aligned regions or lie inside one block,
  // so the containing block decides for every address-based operation
  wp_region_match #(
    .BLK_W      (BLK_W),
    .LVL_W      (LVL_W),
    .TOP_ANCHOR (TOP_ANCHOR)
  ) u_match (
    .blk   (op_addr[ADDR_W-1:BLK_LSB]),
    .level (level),
    .hit   (region_hit)
  );

  assign kind = op_kind_e'(op_kind);

  always_comb begin
    if (kind == OP_CHIP_ERASE)
      allow_d = (level == '0);
    else
      allow_d = !region_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      op_allow <= 1'b0;
      op_err   <= 1'b0;
    end else begin
      op_valid <= op_req;
      op_allow <= op_req && allow_d;
      op_err   <= op_req && !allow_d;
    end
  end

  always_comb begin
    sr_rdback = '0;
    sr_rdback[RB_LOCK_POS] = lock;
    sr_rdback[RB_LVL_LSB +: LVL_W] = level;
  end

endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk #(
  parameter int LVL_W = 3,
  parameter int RB_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sr_wr_en,
  input logic [LVL_W-1:0] sr_wr_level,
  input logic             sr_wr_lock,
  input logic             wp_pin,
  input logic             op_req,
  input logic [1:0]       op_kind,
  input logic             op_valid,
  input logic             op_allow,
  input logic             op_err,
  input logic [RB_W-1:0]  sr_rdback
);

  import flash_wp_pkg::*;

  a_r1_reset_fields: assert property (@(posedge clk)
    rst |=> (sr_rdback[RB_LVL_LSB +: LVL_W] == '1) && !sr_rdback[RB_LOCK_POS] && !op_valid);

  a_r2_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (sr_rdback[6:5] == 2'b00) && (sr_rdback[1:0] == 2'b00));

  a_r3_write_taken: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_en && (wp_pin || !sr_rdback[RB_LOCK_POS])) |=>
      (sr_rdback[RB_LVL_LSB +: LVL_W] == $past(sr_wr_level)) &&
      (sr_rdback[RB_LOCK_POS] == $past(sr_wr_lock)));

  a_r4_locked_frozen: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_en && !wp_pin && sr_rdback[RB_LOCK_POS]) |=> $stable(sr_rdback));

  a_r8_chip_needs_clear: assert property (@(posedge clk) disable iff (rst)
    (op_req && (op_kind == 2'd3) && (sr_rdback[RB_LVL_LSB +: LVL_W] != '0)) |=> !op_allow);

  a_r9_strobe_follows_req: assert property (@(posedge clk) disable iff (rst)
    op_req |=> op_valid);

  a_r9_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
    !op_req |=> !op_valid && !op_allow && !op_err);

  a_r9_err_is_denial: assert property (@(posedge clk) disable iff (rst)
    op_err |-> (op_valid && !op_allow));

  a_r9_denial_flags_err: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_allow) |-> op_err);

endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(.LVL_W(LVL_W), .RB_W(RB_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sr_wr_en    (sr_wr_en),
  .sr_wr_level (sr_wr_level),
  .sr_wr_lock  (sr_wr_lock),
  .wp_pin      (wp_pin),
  .op_req      (op_req),
  .op_kind     (op_kind),
  .op_valid    (op_valid),
  .op_allow    (op_allow),
  .op_err      (op_err),
  .sr_rdback   (sr_rdback)
);

// File: tb/flash_wp_ctrl_bench.sv
`timescale 1ns/1ps
module flash_wp_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sr_wr_en = 1'b0;
  logic [2:0]  sr_wr_level = 3'd0;
  logic        sr_wr_lock = 1'b0;
  logic        wp_pin = 1'b1;
  logic        op_req = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [19:0] op_addr = 20'd0;

  logic       v_t, a_t, e_t, v_b, a_b, e_b;
  logic [7:0] rb_t, rb_b;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  int  cur_lvl = 7;

  always #4 clk = ~clk;

  flash_wp_ctrl #(.TOP_ANCHOR(1'b1)) u_flash_wp_ctrl (
    .clk(clk), .rst(rst), .sr_wr_en(sr_wr_en), .sr_wr_level(sr_wr_level),
    .sr_wr_lock(sr_wr_lock), .wp_pin(wp_pin), .op_req(op_req),
    .op_kind(op_kind), .op_addr(op_addr), .op_valid(v_t), .op_allow(a_t),
    .op_err(e_t), .sr_rdback(rb_t));

  flash_wp_ctrl #(.TOP_ANCHOR(1'b0)) u_flash_wp_ctrl_bot (
    .clk(clk), .rst(rst), .sr_wr_en(sr_wr_en), .sr_wr_level(sr_wr_level),
    .sr_wr_lock(sr_wr_lock), .wp_pin(wp_pin), .op_req(op_req),
    .op_kind(op_kind), .op_addr(op_addr), .op_valid(v_b), .op_allow(a_b),
    .op_err(e_b), .sr_rdback(rb_b));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_allow(bit top, int lvl, int kind, int addr);
    int blk = (addr >> 16) & 15;
    int n = (lvl == 0) ? 0 : (lvl >= 5) ? 16 : (1 << (lvl - 1));
    bit hit = top ? (blk >= 16 - n) : (blk < n);
    if (kind == 3) return (lvl == 0);
    return !hit;
  endfunction

  task automatic sr_write(bit pin, int lvl, bit lk);
    @(negedge clk);
    wp_pin = pin; sr_wr_en = 1'b1; sr_wr_level = 3'(lvl); sr_wr_lock = lk;
    @(negedge clk);
    sr_wr_en = 1'b0;
  endtask

  task automatic run_op(int kind, int addr, string req);
    bit et, eb;
    @(negedge clk);
    op_req = 1'b1; op_kind = 2'(kind); op_addr = 20'(addr);
    @(negedge clk);
    op_req = 1'b0;
    et = exp_allow(1'b1, cur_lvl, kind, addr);
    eb = exp_allow(1'b0, cur_lvl, kind, addr);
    chk("R9", "top valid", int'(v_t), 1);
    chk(req, "top allow", int'(a_t), int'(et));
    chk("R9", "top err", int'(e_t), int'(!et));
    chk("R9", "bottom valid", int'(v_b), 1);
    chk(req == "R5" ? "R6" : req, "bottom allow", int'(a_b), int'(eb));
    chk("R9", "bottom err", int'(e_b), int'(!eb));
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "top rdback", int'(rb_t), 'h1C);
    chk("R1", "bottom rdback", int'(rb_b), 'h1C);
    chk("R1", "no strobe", int'(v_t | v_b | e_t | e_b), 0);

    // R1/R8: reset level forbids chip erase, protects everything
    cur_lvl = 7;
    run_op(3, 'h12345, "R8");
    run_op(0, 'h00000, "R5");

    // R5 R6 R7 R8: sweep every level, kind, block and several sectors
    for (int lvl = 0; lvl < 8; lvl++) begin
      sr_write(1'b1, lvl, 1'b0);
      cur_lvl = lvl;
      chk("R2", "rdback level", int'(rb_t), lvl << 2);
      chk("R3", "bottom rdback level", int'(rb_b), lvl << 2);
      for (int kind = 0; kind < 4; kind++)
        for (int blk = 0; blk < 16; blk++)
          for (int s = 0; s < 3; s++) begin
            int sec = (s == 0) ? 0 : (s == 1) ? 7 : 15;
            int addr = (blk << 16) | (sec << 12) | ((sec * 37 + blk) & 'hFFF);
            run_op(kind, addr, kind == 3 ? "R8" : (kind == 0 ? "R5" : "R7"));
          end
    end

    // R9: strobe lasts one cycle
    @(negedge clk);
    chk("R9", "strobe drop", int'(v_t | v_b | e_t | e_b | a_t | a_b), 0);

    // R3 R4: lock-down interplay with the pin
    sr_write(1'b1, 0, 1'b1);
    cur_lvl = 0;
    chk("R3", "lock set with pin high", int'(rb_t), 'h80);
    sr_write(1'b0, 7, 1'b0);
    chk("R4", "locked write dropped", int'(rb_t), 'h80);
    chk("R4", "locked write dropped bottom", int'(rb_b), 'h80);
    run_op(3, 'h00000, "R8");
    sr_write(1'b1, 3, 1'b1);
    cur_lvl = 3;
    chk("R3", "pin high overrides lock", int'(rb_t), 'h8C);
    sr_write(1'b0, 0, 1'b0);
    chk("R4", "frozen again", int'(rb_t), 'h8C);
    run_op(0, 'hC0000, "R5");
    run_op(3, 'h00000, "R8");
    sr_write(1'b1, 5, 1'b0);
    cur_lvl = 5;
    chk("R3", "unlock with pin high", int'(rb_t), 'h14);
    sr_write(1'b0, 2, 1'b0);
    cur_lvl = 2;
    chk("R3", "pin low unlocked", int'(rb_t), 'h08);
    run_op(1, 'hE7000, "R7");
    run_op(2, 'h1F000, "R7");

    // R9: same-cycle write does not affect the decision
    @(negedge clk);
    sr_wr_en = 1'b1; sr_wr_level = 3'd0; sr_wr_lock = 1'b0; wp_pin = 1'b1;
    op_req = 1'b1; op_kind = 2'd3; op_addr = 20'h0;
    @(negedge clk);
    sr_wr_en = 1'b0; op_req = 1'b0;
    chk("R9", "old fields used", int'(a_t), 0);
    chk("R9", "err on old fields", int'(e_t), 1);
    cur_lvl = 0;

    // R1: reset overrides lock and pin
    sr_write(1'b1, 1, 1'b1);
    wp_pin = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "reset with lock", int'(rb_t), 'h1C);
    chk("R1", "reset with lock bottom", int'(rb_b), 'h1C);
    summary();
  end

endmodule